// File: doc/BRIEF.md
# Static Memory Write Strobe Sequencer

This block runs one write access at a time to an external asynchronous static memory. A requester offers an address, a data word and byte enables through a valid/ready handshake. The block then steps through a programmed number of clocks. During that time it drives an active-low write-enable strobe and an active-low chip-select strobe, each with its own setup delay and pulse width. It also drives the address and active-low byte selects, and a data-bus output enable that says when the write data should be on the bus.

All timing values are static configuration inputs counted in controller clocks. A programmed pulse of zero is treated as one. The total access length is the programmed cycle length, stretched when needed so that both strobe pulses finish inside it. One mode input selects which strobe the memory samples the write on, and this choice moves the start of data drive. If a new request is waiting in the last clock of an access, the next access starts on the following clock with no gap. With zero setup and zero hold, a strobe therefore stays low across back-to-back writes.

The controller is a two-state machine, `ST_IDLE` and `ST_WRITE`, with a phase counter. It moves from `ST_IDLE` to `ST_WRITE` when a request is accepted. It stays in `ST_WRITE` while the phase advances, and restarts `ST_WRITE` at phase 0 when a request is accepted in the last phase. It moves from `ST_WRITE` back to `ST_IDLE` when the last phase ends with no request.

Top module: `smw_write_seq`

## Requirements
- R1: After reset the block is idle: `mem_we_n` and `mem_cs_n` are 1, `mem_doe` is 0 and `req_ready` is 1.
- R2: Number the clocks of an access from phase 0, the first clock after acceptance. `mem_we_n` is 0 exactly in phases `cfg_we_setup` up to, but not including, `cfg_we_setup` + P_we, where P_we is the effective write-enable pulse.
- R3: `mem_cs_n` is 0 exactly in phases `cfg_cs_setup` up to, but not including, `cfg_cs_setup` + P_cs, where P_cs is the effective chip-select pulse.
- R4: The effective pulse equals the programmed pulse value, except that a programmed value of 0 gives a pulse of 1 clock.
- R5: An access lasts L = max(`cfg_cycle`, `cfg_we_setup` + P_we, `cfg_cs_setup` + P_cs) clocks. During an access, `req_ready` is 1 only in phase L-1.
- R6: When `cfg_we_ctrl` = 1, `mem_doe` is 1 from phase `cfg_we_setup` through phase L-1. When `cfg_we_ctrl` = 0, it is 1 from phase `cfg_cs_setup` through phase L-1. In both modes the other strobe's waveform has no effect on it.
- R7: Through every phase of an access, `mem_addr` and `mem_dout` equal the accepted address and data, and `mem_be_n` equals the bitwise inverse of the accepted `req_be`.
- R8: A request accepted in phase L-1 starts its phase 0 on the next clock. A strobe whose setup is 0 and whose pulse ends at L therefore stays 0 across the boundary between the two accesses.
- R9: When phase L-1 ends with no request, the next clock is idle: both strobes are 1, `mem_doe` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_setup | input | TW | Write-enable setup, in clocks |
| cfg_we_pulse | input | TW | Write-enable pulse, in clocks (0 is treated as 1) |
| cfg_cycle | input | TW | Total access length, in clocks |
| cfg_cs_setup | input | TW | Chip-select setup, in clocks |
| cfg_cs_pulse | input | TW | Chip-select pulse, in clocks (0 is treated as 1) |
| cfg_we_ctrl | input | 1 | 1: write-enable controls the write; 0: chip-select controls it |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | A request is taken on this clock edge if valid |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| mem_addr | output | AW | Address to the memory |
| mem_be_n | output | DW/8 | Byte selects, active low |
| mem_dout | output | DW | Write data to the memory |
| mem_doe | output | 1 | Data-bus output enable |
| mem_we_n | output | 1 | Write-enable strobe, active low |
| mem_cs_n | output | 1 | Chip-select strobe, active low |

## Verification
Two functions can meet in the same clock: the end of one access, where `req_ready` is 1 and the hold phase is still running, and the start of the next access, which is triggered by a pending request. The bench provokes this by keeping `req_valid` high with a fresh address and data word through the last phase of every first access, across a near-exhaustive sweep of setups, pulses (including zero), cycle lengths and both modes. On every clock it compares the strobes, `mem_doe` and the bus values with a waveform worked out arithmetically from the settings. This confirms that the second access begins at phase 0 with no idle clock, and that a zero-setup, zero-hold strobe never goes high at the seam.

// File: rtl/smw_pkg.sv
package smw_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } smw_state_e;

    localparam int unsigned NUM_STROBES = 2;
    localparam int unsigned IDX_WE      = 0;
    localparam int unsigned IDX_CS      = 1;

endpackage

// File: rtl/smw_timing.sv
module smw_timing
    import smw_pkg::*;
#(
    parameter int unsigned TW = 4,
    parameter int unsigned CW = TW + 2
) (
    input  logic [NUM_STROBES-1:0][TW-1:0] setup_i,
    input  logic [NUM_STROBES-1:0][TW-1:0] pulse_i,
    input  logic [TW-1:0]                  cycle_i,
    output logic [NUM_STROBES-1:0][CW-1:0] start_o,
    output logic [NUM_STROBES-1:0][CW-1:0] stop_o,
    output logic [CW-1:0]                  last_idx_o
);

    logic [NUM_STROBES-1:0][CW-1:0] eff_pulse;
    logic [CW-1:0]                  span_max;
    logic [CW-1:0]                  total_len;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
        // R4: a zero pulse is clamped to one clock
        always_comb begin
            if (pulse_i[g] == '0) begin
                eff_pulse[g] = CW'(1);
            end else begin
                eff_pulse[g] = CW'(pulse_i[g]);
            end
            start_o[g] = CW'(setup_i[g]);
            stop_o[g]  = CW'(setup_i[g]) + eff_pulse[g];
        end
    end

    // R5: the access is stretched to cover both pulses
    always_comb begin
        span_max = (stop_o[IDX_WE] > stop_o[IDX_CS]) ? stop_o[IDX_WE] : stop_o[IDX_CS];
        total_len = (CW'(cycle_i) > span_max) ? CW'(cycle_i) : span_max;
        last_idx_o = total_len - CW'(1);
    end

    always_comb begin
        a_r4_pulse_nonzero: assert (stop_o[IDX_WE] > start_o[IDX_WE] && stop_o[IDX_CS] > start_o[IDX_CS])
            else $error("R4: strobe pulse of zero length");
    end

endmodule

// File: rtl/smw_fsm.sv
module smw_fsm
    import smw_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [CW-1:0] last_idx_i,
    output smw_state_e    state_o,
    output logic [CW-1:0] phase_o,
    output logic          ready_o,
    output logic          accept_o
);

    smw_state_e    state_q, state_d;
    logic [CW-1:0] phase_q, phase_d;
    logic          at_last;

    always_comb begin
        at_last  = (state_q == ST_WRITE) && (phase_q == last_idx_i);
        ready_o  = (state_q == ST_IDLE) || at_last;
        accept_o = req_valid_i && ready_o;
    end

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    state_d = ST_WRITE;
                    phase_d = '0;
                end
            end
            ST_WRITE: begin
                if (accept_o) begin
                    state_d = ST_WRITE;
                    phase_d = '0;
                end else if (at_last) begin
                    state_d = ST_IDLE;
                    phase_d = '0;
                end else begin
                    phase_d = phase_q + CW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                phase_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    assign state_o = state_q;
    assign phase_o = phase_q;

    a_r5_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |-> (phase_q <= last_idx_i))
        else $error("R5: phase past the last index");

    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && req_valid_i) |=> (state_q == ST_WRITE && phase_q == '0))
        else $error("R8: back-to-back access did not restart at phase 0");

endmodule

// File: rtl/smw_strobes.sv
module smw_strobes
    import smw_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  smw_state_e                     state_i,
    input  logic [CW-1:0]                  phase_i,
    input  logic [NUM_STROBES-1:0][CW-1:0] start_i,
    input  logic [NUM_STROBES-1:0][CW-1:0] stop_i,
    input  logic                           we_ctrl_i,
    output logic                           we_n_o,
    output logic                           cs_n_o,
    output logic                           doe_o
);

    logic [NUM_STROBES-1:0] active;
    logic [CW-1:0]          drive_from;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_win
        always_comb begin
            active[g] = (state_i == ST_WRITE) &&
                        (phase_i >= start_i[g]) && (phase_i < stop_i[g]);
        end
    end

    // R6: data drive begins after the setup of the controlling strobe
    always_comb begin
        drive_from = we_ctrl_i ? start_i[IDX_WE] : start_i[IDX_CS];
        we_n_o = !active[IDX_WE];
        cs_n_o = !active[IDX_CS];
        doe_o  = (state_i == ST_WRITE) && (phase_i >= drive_from);
    end

    a_r6_data_under_we: assert property (@(posedge clk) disable iff (!rst_n)
        (we_ctrl_i && !we_n_o) |-> doe_o)
        else $error("R6: write-enable low without data drive");

    a_r6_data_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_ctrl_i && !cs_n_o) |-> doe_o)
        else $error("R6: chip-select low without data drive");

endmodule

// File: rtl/smw_write_seq.sv
module smw_write_seq
    import smw_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16,
    parameter int unsigned TW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   cfg_we_setup,
    input  logic [TW-1:0]   cfg_we_pulse,
    input  logic [TW-1:0]   cfg_cycle,
    input  logic [TW-1:0]   cfg_cs_setup,
    input  logic [TW-1:0]   cfg_cs_pulse,
    input  logic            cfg_we_ctrl,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_data,
    input  logic [DW/8-1:0] req_be,
    output logic [AW-1:0]   mem_addr,
    output logic [DW/8-1:0] mem_be_n,
    output logic [DW-1:0]   mem_dout,
    output logic            mem_doe,
    output logic            mem_we_n,
    output logic            mem_cs_n
);

    localparam int unsigned CW = TW + 2;
    localparam int unsigned BW = DW / 8;

    logic [NUM_STROBES-1:0][TW-1:0] setup_vec;
    logic [NUM_STROBES-1:0][TW-1:0] pulse_vec;
    logic [NUM_STROBES-1:0][CW-1:0] start_vec;
    logic [NUM_STROBES-1:0][CW-1:0] stop_vec;
    logic [CW-1:0]                  last_idx;
    smw_state_e                     state;
    logic [CW-1:0]                  phase;
    logic                           accept;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [BW-1:0] be_q;

    always_comb begin
        setup_vec[IDX_WE] = cfg_we_setup;
        setup_vec[IDX_CS] = cfg_cs_setup;
        pulse_vec[IDX_WE] = cfg_we_pulse;
        pulse_vec[IDX_CS] = cfg_cs_pulse;
    end

    smw_timing #(.TW(TW), .CW(CW)) u_timing (
        .setup_i    (setup_vec),
        .pulse_i    (pulse_vec),
        .cycle_i    (cfg_cycle),
        .start_o    (start_vec),
        .stop_o     (stop_vec),
        .last_idx_o (last_idx)
    );

    smw_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .last_idx_i  (last_idx),
        .state_o     (state),
        .phase_o     (phase),
        .ready_o     (req_ready),
        .accept_o    (accept)
    );

    smw_strobes #(.CW(CW)) u_strobes (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .phase_i   (phase),
        .start_i   (start_vec),
        .stop_i    (stop_vec),
        .we_ctrl_i (cfg_we_ctrl),
        .we_n_o    (mem_we_n),
        .cs_n_o    (mem_cs_n),
        .doe_o     (mem_doe)
    );

    // R7: request fields are captured once per access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            be_q   <= req_be;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dout = data_q;
    assign mem_be_n = ~be_q;

    a_r7_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !accept) |=> ($stable(mem_addr) && $stable(mem_dout) && $stable(mem_be_n)))
        else $error("R7: bus values moved inside an access");

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && req_ready && !req_valid) |=> (mem_we_n && mem_cs_n && !mem_doe && req_ready))
        else $error("R9: strobes not released after the last access");

endmodule

// File: tb/smw_write_seq_bench.sv
`timescale 1ns/1ps
module smw_write_seq_bench;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TW-1:0]   cfg_we_setup = '0, cfg_we_pulse = '0, cfg_cycle = '0;
    logic [TW-1:0]   cfg_cs_setup = '0, cfg_cs_pulse = '0;
    logic            cfg_we_ctrl = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_data = '0;
    logic [DW/8-1:0] req_be = '0;
    logic [AW-1:0]   mem_addr;
    logic [DW/8-1:0] mem_be_n;
    logic [DW-1:0]   mem_dout;
    logic            mem_doe, mem_we_n, mem_cs_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    smw_write_seq #(.AW(AW), .DW(DW), .TW(TW)) u_smw_write_seq (
        .clk, .rst_n, .cfg_we_setup, .cfg_we_pulse, .cfg_cycle,
        .cfg_cs_setup, .cfg_cs_pulse, .cfg_we_ctrl,
        .req_valid, .req_ready, .req_addr, .req_data, .req_be,
        .mem_addr, .mem_be_n, .mem_dout, .mem_doe, .mem_we_n, .mem_cs_n
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seq = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
        check(mem_cs_n == 1'b1, "R1 cs_n", mem_cs_n, 1);
        check(mem_doe == 1'b0, "R1 doe", mem_doe, 0);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int mode = 0; mode < 2; mode++)
        for (int cyc = 0; cyc < 8; cyc += 3)
        for (int ws = 0; ws < 3; ws++)
        for (int wp = 0; wp < 3; wp++)
        for (int cs = 0; cs < 3; cs++)
        for (int cp = 0; cp < 3; cp++) begin
            int pwe, pcs, len, dfrom;
            logic [AW-1:0] a_exp [2];
            logic [DW-1:0] d_exp [2];
            logic [1:0]    b_exp [2];
            pwe = (wp == 0) ? 1 : wp;          // R4
            pcs = (cp == 0) ? 1 : cp;          // R4
            len = maxi(cyc, maxi(ws + pwe, cs + pcs));
            dfrom = (mode == 1) ? ws : cs;
            cfg_we_ctrl  = mode[0];
            cfg_cycle    = TW'(cyc);
            cfg_we_setup = TW'(ws);
            cfg_we_pulse = TW'(wp);
            cfg_cs_setup = TW'(cs);
            cfg_cs_pulse = TW'(cp);
            for (int k = 0; k < 2; k++) begin
                seq++;
                a_exp[k] = AW'(16'h1357 * seq);
                d_exp[k] = DW'(16'hA5C3 ^ (seq * 77));
                b_exp[k] = 2'(seq);
            end
            req_valid = 1'b1;
            req_addr = a_exp[0];
            req_data = d_exp[0];
            req_be = b_exp[0];
            @(posedge clk);
            for (int k = 0; k < 2; k++) begin
                for (int t = 0; t < len; t++) begin
                    bit we_exp, cs_exp, oe_exp, rdy_exp;
                    @(negedge clk);
                    we_exp  = !(t >= ws && t < ws + pwe);
                    cs_exp  = !(t >= cs && t < cs + pcs);
                    oe_exp  = (t >= dfrom);
                    rdy_exp = (t == len - 1);
                    check(mem_we_n == we_exp, (k == 1 && t == 0) ? "R8 we_n seam" : "R2 we_n", mem_we_n, we_exp);
                    check(mem_cs_n == cs_exp, (k == 1 && t == 0) ? "R8 cs_n seam" : "R3 cs_n", mem_cs_n, cs_exp);
                    check(mem_doe == oe_exp, "R6 doe", mem_doe, oe_exp);
                    check(req_ready == rdy_exp, "R5 ready", req_ready, rdy_exp);
                    check(mem_addr == a_exp[k], "R7 addr", mem_addr, a_exp[k]);
                    check(mem_dout == d_exp[k], "R7 data", mem_dout, d_exp[k]);
                    check(mem_be_n == ~b_exp[k], "R7 be_n", mem_be_n, ~b_exp[k]);
                    if (t == len - 1) begin
                        if (k == 0) begin
                            req_addr = a_exp[1];
                            req_data = d_exp[1];
                            req_be = b_exp[1];
                        end else begin
                            req_valid = 1'b0;
                            req_addr = '1;
                            req_data = '1;
                        end
                    end
                    @(posedge clk);
                end
            end
            @(negedge clk);
            // R9: released one clock after the last access
            check(mem_we_n == 1'b1, "R9 we_n", mem_we_n, 1);
            check(mem_cs_n == 1'b1, "R9 cs_n", mem_cs_n, 1);
            check(mem_doe == 1'b0, "R9 doe", mem_doe, 0);
            check(req_ready == 1'b1, "R9 ready", req_ready, 1);
            check(mem_addr == a_exp[1], "R7 addr hold", mem_addr, a_exp[1]);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule